// File: doc/BRIEF.md
# Split-Byte Delayed Sample Output Formatter

This block sits behind a 14-bit converter. It turns the stream of conversion results into reads on a narrow byte-wide bus. A sample strobe marks each new result and the channel tag that goes with it. The block holds every result for a fixed number of strobes and then shows it as two bytes, high part first and low part second. The core clock runs at twice the sample rate and is aligned to the strobe. The high byte therefore occupies the core cycle that follows a strobe, and the low byte occupies the cycle after that.

A phase output tells the receiver which byte is on the bus. A tag output names the channel of the word being shown, for example red, green or blue when the source interleaves three colours one per sample period. A valid flag marks the point where the delay line holds real samples instead of reset contents. An active-low enable releases the bus to high impedance. It has no effect on the delay line.

Top module: `split_byte_formatter`

## Requirements
- R1: A result accepted on strobe number k (strobe = `sample_stb` high at a rising clock edge) is presented starting in the cycle after the edge that accepts strobe k+9. The delay is counted in strobes, not in clock cycles.
- R2: In the cycle after an edge where a strobe is accepted, `byte_hi` is 1 and, with the bus enabled, `dq` carries bits 13..6 of the presented word.
- R3: In every other cycle, `byte_hi` is 0 and `dq` carries {2'b00, word bits 5..0}. Without strobes the low byte stays on the bus unchanged.
- R4: While `oe_n` is 1, all bits of `dq` are high impedance. `oe_n` changes neither the delay line nor any other output.
- R5: `tag_q` is the `sample_tag` that was accepted with the presented word, delayed by the same 9 strobes.
- R6: `word_valid` is 0 after reset until the first accepted result is presented (the 10th strobe). From then on it stays 1 until the next reset.
- R7: While `rst_n` is low and after its release, until R1 applies: `dq` shows 0 when enabled, `tag_q` is 0, `byte_hi` is 0 and `word_valid` is 0. A reset in mid-stream discards all words in flight.
- R8: `sample_data` and `sample_tag` are ignored in cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | Marks a new result; at most one every two cycles |
| sample_data | input | 14 | Conversion result |
| sample_tag | input | 2 | Channel tag of the result |
| oe_n | input | 1 | Active-low bus enable |
| dq | output | 8 | Byte bus, high impedance when disabled |
| byte_hi | output | 1 | 1 during the high-byte read |
| tag_q | output | 2 | Tag of the presented word |
| word_valid | output | 1 | Presented word comes from a real sample |

## Verification
The hardest case to reach is a strobe-counted delay that must not turn into a cycle-counted one. A bench that only ever strobes every second cycle cannot tell the two apart. The stimulus therefore mixes spacings of two, three and five cycles, and it drives changing data and tags between strobes, so that a design that shifts on every clock or samples off-strobe shows the wrong word. A reset in mid-stream, issued after the pipeline is full, forces the refill path and the valid flag to restart.

// File: rtl/split_byte_formatter.sv
module split_byte_formatter #(
  parameter int DW  = 14,
  parameter int BW  = 8,
  parameter int TW  = 2,
  parameter int LAT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_stb,
  input  logic [DW-1:0] sample_data,
  input  logic [TW-1:0] sample_tag,
  input  logic          oe_n,
  output logic [BW-1:0] dq,
  output logic          byte_hi,
  output logic [TW-1:0] tag_q,
  output logic          word_valid
);
  localparam int LW = DW - BW;
  localparam int EW = DW + TW + 1;

  logic [EW-1:0] pipe [LAT];
  logic [DW-1:0] word_q;
  logic [BW-1:0] hi_byte, lo_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
      word_q     <= '0;
      tag_q      <= '0;
      word_valid <= 1'b0;
      byte_hi    <= 1'b0;
    end else begin
      byte_hi <= sample_stb;
      if (sample_stb) begin
        pipe[0] <= {1'b1, sample_tag, sample_data};
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
        {word_valid, tag_q, word_q} <= pipe[LAT-1];
      end
    end
  end

  assign hi_byte = word_q[DW-1 -: BW];
  assign lo_byte = {{(BW-LW){1'b0}}, word_q[LW-1:0]};
  assign dq      = oe_n ? {BW{1'bz}} : (byte_hi ? hi_byte : lo_byte);

  // R3
  lo_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !byte_hi) |-> (dq[BW-1:LW] == '0));

  // R5
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_hi |-> $stable(tag_q));

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> word_valid);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> byte_hi);

  // R4
  always_comb begin
    if (rst_n && oe_n) release_z_chk: assert (dq === {BW{1'bz}});
  end
endmodule

// File: tb/split_byte_formatter_tb.sv
module split_byte_formatter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic [13:0] sample_data = '0;
  logic [1:0] sample_tag = '0;
  logic oe_n = 1'b0;
  logic [7:0] dq;
  logic byte_hi;
  logic [1:0] tag_q;
  logic word_valid;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;
  int seed = 7;
  logic [15:0] hist [$];
  logic m_hi;
  int ns;

  always #2.5 clk = ~clk;

  split_byte_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sample_data(sample_data),
    .sample_tag(sample_tag), .oe_n(oe_n), .dq(dq), .byte_hi(byte_hi),
    .tag_q(tag_q), .word_valid(word_valid));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc_cnt, act, exp);
    end
  endtask

  task automatic step(input logic stb);
    logic [13:0] w;
    logic [1:0] t;
    logic v;
    logic [7:0] eb;
    @(posedge clk);
    cyc_cnt++;
    if (!rst_n) begin
      hist.delete();
      ns = 0;
      m_hi = 1'b0;
    end else begin
      m_hi = sample_stb;
      if (sample_stb) begin
        hist.push_back({sample_tag, sample_data});
        ns++;
      end
    end
    @(negedge clk);
    v = (ns >= 10);
    w = v ? hist[ns-10][13:0] : 14'h0;
    t = v ? hist[ns-10][15:14] : 2'h0;
    if (oe_n) eb = 8'hzz;
    else if (m_hi) eb = w[13:6];
    else eb = {2'b00, w[5:0]};
    // R1 R2 R3 R4 R7: byte on the bus
    chk(oe_n ? "R4" : (m_hi ? "R1 R2" : "R1 R3"), dq, eb);
    chk("R2 R3 phase", {7'b0, byte_hi}, {7'b0, m_hi});
    chk("R5 tag", {6'b0, tag_q}, {6'b0, t});
    chk("R6 valid", {7'b0, word_valid}, {7'b0, v});
    sample_stb = stb;
    seed = seed * 1103515245 + 12345;
    // R8: data and tag change every cycle, also between strobes
    sample_data = seed[29:16];
    sample_tag = seed[17:16] % 3;
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 1; g < gap; g++) step(1'b0);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ns = 0;
    m_hi = 1'b0;
    // R7: reset state
    for (int i = 0; i < 4; i++) step(1'b0);
    @(negedge clk) rst_n = 1'b1;
    run(12, 2);
    // boundary words
    for (int i = 0; i < 3; i++) begin
      step(1'b1); sample_data = 14'h3FFF;
      step(1'b0); sample_data = 14'h3FFF;
      step(1'b1); sample_data = 14'h0000;
      step(1'b0);
    end
    run(10, 3);
    run(10, 5);
    // R4: toggle enable while streaming
    oe_n = 1'b1;
    run(6, 2);
    oe_n = 1'b0;
    step(1'b0);
    oe_n = 1'b1;
    step(1'b1);
    oe_n = 1'b0;
    run(12, 2);
    // R7: reset mid-stream, then refill
    @(negedge clk) rst_n = 1'b0;
    step(1'b0);
    step(1'b1);
    @(negedge clk) rst_n = 1'b1;
    run(14, 2);
    run(20, 4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule